// File: doc/BRIEF.md
# Token-Chained Serial Row Readout

This block is one chip's share of a readout chain in which many chips hang on one shared open-collector data line. A token enters the first chip in the chain. While a chip holds the token, it reads its stored rows from a local memory and sends them one bit per readout clock on the shared line. When it has finished, it hands the token to the next chip. Only the chip that holds the token ever pulls the line, so the chips transmit one after another in chain order.

Each stored row is a fixed-width word. It holds a header byte, then a field of channel hit bits, then a bunch-crossing tag, and the word is sent from its most significant bit down. The block drives a pull-down enable rather than a logic level: the line reads high unless some chip pulls it. A slow-control skip input lets a chip pass the token on at once without sending anything. A chip that holds no rows does the same. The readout clock is meant to run at a few MHz, which keeps switching power low on the heavily loaded shared line.

Top module: `rdo_chain_slice`

## Requirements
- R1: After a synchronous reset, including a reset asserted in the middle of a readout, `tok_out`, `line_pull` and `busy` are all 0, and the chip stays idle until the next rising edge of `tok_in`.
- R2: Only a rising edge of `tok_in` seen while the chip is idle starts a readout, and `busy` goes high in the cycle after that edge. A level held high, or a new edge during a readout, does not restart it.
- R3: A row is `rd_data` taken as {header[167:160], hits[159:32], tag[31:0]}. It is sent most significant bit first, one bit per clock. The first bit is on the line two cycles after the token edge is sampled.
- R4: Rows go out in address order 0 to N-1, where N is `row_count` captured at the token edge. `rd_data` is a combinational read of `rd_addr`. Consecutive rows follow each other with no idle clock between them.
- R5: `line_pull` is high exactly while a 0 bit is being sent. It is never high outside a readout.
- R6: After the last bit, the line is released for one clock. `tok_out` is asserted in the clock after that.
- R7: `tok_out` is high for exactly one clock per token received.
- R8: With `skip_en` high, the chip asserts `tok_out` in the cycle after the token edge and never pulls the line.
- R9: With `row_count` equal to 0, the chip behaves as in R8.
- R10: In a chain where each `tok_out` feeds the next chip's `tok_in`, at most one chip pulls the line in any cycle, and data appears strictly in chain order.
- R11: `busy` is high from the cycle after the token edge up to and including the `tok_out` cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_in | input | 1 | Token from the previous chip or from the acquisition system; its rising edge is used |
| skip_en | input | 1 | Slow-control skip: pass the token on without sending |
| row_count | input | 8 | Number of stored rows (0 to 128) |
| rd_addr | output | 7 | Row address for the local memory |
| rd_data | input | 168 | Row word read combinationally at `rd_addr` |
| tok_out | output | 1 | One-clock token pulse to the next chip |
| line_pull | output | 1 | Pull-down enable for the shared open-collector line |
| busy | output | 1 | Chip holds the token |

## Verification
The bench builds a three-chip chain and resolves the shared line as a wired-AND. It then runs the chain over a table of row counts and skip masks. Chips with several rows show whether rows are contiguous and in address order. Chips with one row show the header, hit and tag boundaries. Mixes of empty and skipped chips placed first, in the middle and last show whether the immediate pass-through keeps the next chip's start cycle exact. Three token drives are used: a single pulse, a held level, and a drop-and-re-raise during a readout. Together they separate true edge detection from level triggering. A reset asserted mid-stream shows that the line and token are released at once.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    localparam int unsigned HDR_BITS = 8;
    localparam int unsigned HIT_BITS = 128;
    localparam int unsigned TAG_BITS = 32;
    localparam int unsigned ROW_DEPTH = 128;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP,
        ST_PASS
    } rdo_state_e;

    // control word from the sequencer to the datapath and port decode
    typedef struct packed {
        logic load;
        logic shift;
        logic send;
        logic pass;
        logic busy;
    } rdo_ctl_t;

    function automatic int unsigned row_bits(input int unsigned h, input int unsigned d,
                                             input int unsigned t);
        return h + d + t;
    endfunction

endpackage

// File: rtl/rdo_tok_edge.sv
module rdo_tok_edge (
    input  logic clk,
    input  logic tok_in,
    output logic rise
);
    logic tok_prev;

    // previous level is tracked through reset so a level held over reset never counts as an edge
    always_ff @(posedge clk) begin
        tok_prev <= tok_in;
    end

    assign rise = tok_in & ~tok_prev;
endmodule

// File: rtl/rdo_seq.sv
module rdo_seq
    import rdo_pkg::*;
#(
    parameter int unsigned ROW_W  = 168,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              skip_en,
    input  logic [CNT_W-1:0]  row_count,
    output logic [ADDR_W-1:0] rd_addr,
    output rdo_ctl_t          ctl
);
    localparam int unsigned BIT_W = $clog2(ROW_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(ROW_W - 1);

    rdo_state_e       state_q, state_d;
    logic [CNT_W-1:0] rows_q, rows_d;
    logic [CNT_W-1:0] nxt_q, nxt_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic             last_bit;
    logic             more_rows;

    assign last_bit  = (bit_q == LAST_BIT);
    assign more_rows = (nxt_q < rows_q);

    always_comb begin
        state_d   = state_q;
        rows_d    = rows_q;
        nxt_d     = nxt_q;
        bit_d     = bit_q;
        ctl       = '0;
        ctl.busy  = (state_q != ST_IDLE);
        ctl.send  = (state_q == ST_SHIFT);
        ctl.pass  = (state_q == ST_PASS);
        unique case (state_q)
            ST_IDLE: begin
                if (rise) begin
                    rows_d  = row_count;
                    nxt_d   = '0;
                    state_d = (skip_en || row_count == '0) ? ST_PASS : ST_LOAD;
                end
            end
            ST_LOAD: begin
                ctl.load = 1'b1;
                nxt_d    = nxt_q + 1'b1;
                bit_d    = '0;
                state_d  = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!last_bit) begin
                    ctl.shift = 1'b1;
                    bit_d     = bit_q + 1'b1;
                end else if (more_rows) begin
                    ctl.load = 1'b1;
                    nxt_d    = nxt_q + 1'b1;
                    bit_d    = '0;
                end else begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP:  state_d = ST_PASS;
            ST_PASS: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rows_q  <= '0;
            nxt_q   <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            rows_q  <= rows_d;
            nxt_q   <= nxt_d;
            bit_q   <= bit_d;
        end
    end

    assign rd_addr = nxt_q[ADDR_W-1:0];
endmodule

// File: rtl/rdo_shreg.sv
module rdo_shreg #(
    parameter int unsigned ROW_W = 168
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [ROW_W-1:0] din,
    output logic             msb
);
    logic [ROW_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= din;
        end else if (shift) begin
            sr_q <= {sr_q[ROW_W-2:0], 1'b1};
        end
    end

    assign msb = sr_q[ROW_W-1];
endmodule

// File: rtl/rdo_chain_slice.sv
module rdo_chain_slice
    import rdo_pkg::*;
#(
    parameter int unsigned HDR_W = rdo_pkg::HDR_BITS,
    parameter int unsigned HIT_W = rdo_pkg::HIT_BITS,
    parameter int unsigned TAG_W = rdo_pkg::TAG_BITS,
    parameter int unsigned DEPTH = rdo_pkg::ROW_DEPTH,
    localparam int unsigned ROW_W  = rdo_pkg::row_bits(HDR_W, HIT_W, TAG_W),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_in,
    input  logic              skip_en,
    input  logic [CNT_W-1:0]  row_count,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [ROW_W-1:0]  rd_data,
    output logic              tok_out,
    output logic              line_pull,
    output logic              busy
);
    logic     rise;
    logic     bit_msb;
    rdo_ctl_t ctl;

    rdo_tok_edge u_edge (
        .clk    (clk),
        .tok_in (tok_in),
        .rise   (rise)
    );

    rdo_seq #(
        .ROW_W  (ROW_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .skip_en   (skip_en),
        .row_count (row_count),
        .rd_addr   (rd_addr),
        .ctl       (ctl)
    );

    rdo_shreg #(
        .ROW_W (ROW_W)
    ) u_sr (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.load),
        .shift (ctl.shift),
        .din   (rd_data),
        .msb   (bit_msb)
    );

    // open collector: a 0 bit is a pull, a 1 bit leaves the line released
    assign line_pull = ctl.send & ~bit_msb;
    assign tok_out   = ctl.pass;
    assign busy      = ctl.busy;
endmodule

// File: rtl/rdo_chain_slice_chk.sv
module rdo_chain_slice_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tok_in,
    input logic             skip_en,
    input logic [CNT_W-1:0] row_count,
    input logic             tok_out,
    input logic             line_pull,
    input logic             busy
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && tok_in && !$past(tok_in)) |=> busy);

    p_pull_in_readout_r5: assert property (@(posedge clk) disable iff (rst)
        line_pull |-> busy);

    p_release_before_token_r6: assert property (@(posedge clk) disable iff (rst)
        line_pull |=> !tok_out);

    p_token_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        tok_out |=> !tok_out);

    p_skip_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && tok_in && !$past(tok_in) && skip_en) |=> (tok_out && !line_pull));

    p_empty_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && tok_in && !$past(tok_in) && row_count == '0) |=> tok_out);

    p_token_while_held_r11: assert property (@(posedge clk) disable iff (rst)
        tok_out |-> busy);
endmodule

bind rdo_chain_slice rdo_chain_slice_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tok_in    (tok_in),
    .skip_en   (skip_en),
    .row_count (row_count),
    .tok_out   (tok_out),
    .line_pull (line_pull),
    .busy      (busy)
);

// File: tb/sim_rdo_chain_slice.sv
`timescale 1ns/1ps
module sim_rdo_chain_slice;
    localparam int RW   = 168;
    localparam int MAXC = 1700;
    localparam int NV   = 7;

    // {mode[1:0], skip[2:0], n2[1:0], n1[1:0], n0[1:0]}; mode 0 pulse, 1 hold, 2 bounce
    localparam logic [10:0] VEC [NV] = '{
        {2'd0, 3'b000, 2'd1, 2'd1, 2'd1},
        {2'd0, 3'b000, 2'd3, 2'd0, 2'd2},
        {2'd0, 3'b010, 2'd1, 2'd2, 2'd1},
        {2'd0, 3'b000, 2'd0, 2'd0, 2'd0},
        {2'd1, 3'b101, 2'd2, 2'd1, 2'd3},
        {2'd2, 3'b000, 2'd0, 2'd1, 2'd2},
        {2'd0, 3'b111, 2'd1, 2'd1, 2'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic           tok [4];
    logic           skip [3];
    logic [7:0]     cnt [3];
    logic [6:0]     addr [3];
    logic [RW-1:0]  data [3];
    logic           pull [3];
    logic           bsy [3];
    logic           line;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    function automatic logic [RW-1:0] row_word(input int chip, input int a);
        logic [31:0] h;
        h = 32'h9E3779B9 * 32'(chip * 8 + a + 1);
        return {8'(8'hC0 + chip * 16 + a), {4{h}}, 32'(1000 * chip + 37 * a + 5)};
    endfunction

    assign data[0] = row_word(0, int'(addr[0]));
    assign data[1] = row_word(1, int'(addr[1]));
    assign data[2] = row_word(2, int'(addr[2]));
    assign line    = ~(pull[0] | pull[1] | pull[2]);

    rdo_chain_slice u0 (.clk(clk), .rst(rst), .tok_in(tok[0]), .skip_en(skip[0]),
        .row_count(cnt[0]), .rd_addr(addr[0]), .rd_data(data[0]), .tok_out(tok[1]),
        .line_pull(pull[0]), .busy(bsy[0]));
    rdo_chain_slice u1 (.clk(clk), .rst(rst), .tok_in(tok[1]), .skip_en(skip[1]),
        .row_count(cnt[1]), .rd_addr(addr[1]), .rd_data(data[1]), .tok_out(tok[2]),
        .line_pull(pull[1]), .busy(bsy[1]));
    rdo_chain_slice u2 (.clk(clk), .rst(rst), .tok_in(tok[2]), .skip_en(skip[2]),
        .row_count(cnt[2]), .rd_addr(addr[2]), .rd_data(data[2]), .tok_out(tok[3]),
        .line_pull(pull[2]), .busy(bsy[2]));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    logic exp_line [MAXC];

    initial begin
        tok[0] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            skip[k] = 1'b0;
            cnt[k]  = 8'd0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        chk(!tok[3] && !pull[0] && !pull[1] && !pull[2] && !bsy[0] && !bsy[1] && !bsy[2],
            "R1 reset outputs", {tok[3], bsy[0], bsy[1], bsy[2]}, 0);

        for (int v = 0; v < NV; v++) begin
            int s [3];
            int t [3];
            int mode;
            int e_line, e_busy, e_tok, e_one, e_skip;
            longint a_line, x_line;
            mode = int'(VEC[v][10:9]);
            for (int k = 0; k < 3; k++) begin
                skip[k] = VEC[v][6 + k];
                cnt[k]  = 8'(VEC[v][2*k +: 2]);
            end
            for (int c = 0; c < MAXC; c++) exp_line[c] = 1'b1;
            // expected timeline from R3, R4, R6, R8, R9, R10
            for (int k = 0; k < 3; k++) begin
                s[k] = (k == 0) ? 0 : t[k-1] + 1;
                if (skip[k] || cnt[k] == 0) begin
                    t[k] = s[k];
                end else begin
                    for (int r = 0; r < int'(cnt[k]); r++) begin
                        logic [RW-1:0] w;
                        w = row_word(k, r);
                        for (int j = 0; j < RW; j++)
                            exp_line[s[k] + 1 + r * RW + j] = w[RW - 1 - j];
                    end
                    t[k] = s[k] + int'(cnt[k]) * RW + 2;
                end
            end
            e_line = 0; e_busy = 0; e_tok = 0; e_one = 0; e_skip = 0;
            a_line = 0; x_line = 0;
            @(negedge clk);
            tok[0] = 1'b1;
            for (int c = 0; c <= t[2] + 3; c++) begin
                @(posedge clk);
                @(negedge clk);
                if (line !== exp_line[c]) begin
                    if (e_line == 0) begin a_line = c; x_line = longint'(exp_line[c]); end
                    e_line++;
                end
                for (int k = 0; k < 3; k++) begin
                    if (bsy[k] !== (c >= s[k] && c <= t[k])) e_busy++;
                    if ((skip[k] || cnt[k] == 0) && pull[k]) e_skip++;
                end
                if (tok[3] !== (c == t[2])) e_tok++;
                if ((int'(pull[0]) + int'(pull[1]) + int'(pull[2])) > 1) e_one++;
                if (mode == 0 && c == 0) tok[0] = 1'b0;
                if (mode == 2 && c == 2) tok[0] = 1'b0;
                if (mode == 2 && c == 4) tok[0] = 1'b1;
            end
            tok[0] = 1'b0;
            chk(e_line == 0, $sformatf("R3 R4 R5 line stream v%0d (first bad cycle, exp bit)", v),
                a_line, x_line);
            chk(e_busy == 0, $sformatf("R2 R11 busy window v%0d", v), e_busy, 0);
            chk(e_tok == 0, $sformatf("R6 R7 chain token out v%0d", v), e_tok, 0);
            chk(e_one == 0, $sformatf("R10 single driver v%0d", v), e_one, 0);
            chk(e_skip == 0, $sformatf("R8 R9 skipped or empty silent v%0d", v), e_skip, 0);
            repeat (3) @(negedge clk);
        end

        // R1: reset in the middle of a readout
        skip[0] = 1'b0; skip[1] = 1'b0; skip[2] = 1'b0;
        cnt[0] = 8'd3; cnt[1] = 8'd1; cnt[2] = 8'd1;
        @(negedge clk);
        tok[0] = 1'b1;
        @(negedge clk);
        tok[0] = 1'b0;
        repeat (20) @(negedge clk);
        chk(bsy[0] === 1'b1, "R2 busy before mid reset", bsy[0], 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        begin
            int bad;
            bad = 0;
            for (int c = 0; c < 600; c++) begin
                @(negedge clk);
                if (line !== 1'b1 || tok[3] || bsy[0] || bsy[1] || bsy[2]) bad++;
            end
            chk(bad == 0, "R1 mid-readout reset leaves chain idle", bad, 0);
        end
        finish_run();
    end
endmodule